// File: doc/BRIEF.md
# Turn-Model Mesh Routing Unit

This block makes the routing decision for one switch of a two-dimensional mesh that moves packets by wormhole switching. When a header flit is presented, the block compares the target coordinates with the switch's own coordinates. It checks which output ports are currently held by other packets. It then names the single output port the header should take next: East, West, North, South or Local. If no allowed port is free, it signals a stall instead. Arbitration between input ports, buffering and flit transport belong to the surrounding switch.

Four minimal routing policies are available, chosen by a static selector. Dimension-ordered XY routing is fully deterministic. The three partially adaptive policies each forbid two turns. In the quadrants where those forbidden turns leave two productive directions open, the block takes whichever of the two is free. In all other quadrants it falls back to a single fixed direction. A stalled header keeps its request raised, and the block re-evaluates it on every clock until a port frees up.

The coordinate convention is X growing toward East and Y growing toward South. So North means a smaller Y and West means a smaller X.

Top module: `turn_route_unit`

## Requirements
- R1: The result is registered: a request seen at a rising clock edge produces its answer in the outputs right after that same edge. A granted answer raises `routeValid` for one cycle, with exactly one bit set in `routePort`. The bits are 0 East, 1 West, 2 North, 3 South, 4 Local.
- R2: When the target X and Y both equal the switch coordinates, the Local port (bit 4) is the only candidate. If Local is busy, the answer is a stall.
- R3: Every granted port is minimal. East only when target X > own X, West only when target X < own X, South only when target Y > own Y, North only when target Y < own Y.
- R4: With `algoSel` = 00 (XY), the only candidate is the X-direction port while the X coordinates differ, and the Y-direction port after they match. A busy candidate gives a stall, never a detour.
- R5: With `algoSel` = 01 (West-first), a target X at or below own X is routed exactly as in XY. A target X above own X prefers East, and takes the needed North or South port when East is busy.
- R6: With `algoSel` = 10 (North-last), a target Y at or below own Y is routed exactly as in XY. A target Y above own Y prefers the needed East or West port, and takes South when that one is busy or X already matches.
- R7: With `algoSel` = 11 (Negative-first): a target to the west and south takes West only, and a target to the east and north takes North only. A target both west and north, or both east and south, prefers the X-direction port and takes the Y-direction port when the X port is busy.
- R8: A request whose allowed ports are all busy raises `routeStall` for that cycle, with `routeValid` low and `routePort` zero. A request held over later cycles is re-evaluated each cycle and is granted once a port frees.
- R9: A cycle without `reqValid` yields `routeValid`, `routeStall` and `routePort` all zero after the next edge.
- R10: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | A header flit is waiting for a routing decision |
| algoSel | input | 2 | Routing policy: 00 XY, 01 West-first, 10 North-last, 11 Negative-first |
| curX | input | 4 | X coordinate of this switch |
| curY | input | 4 | Y coordinate of this switch |
| dstX | input | 4 | Target X coordinate from the header |
| dstY | input | 4 | Target Y coordinate from the header |
| portBusy | input | 5 | Output port already held by another packet, same bit order as routePort |
| routeValid | output | 1 | One-cycle pulse: routePort holds a granted port |
| routeStall | output | 1 | The request could not be served this cycle |
| routePort | output | 5 | One-hot granted port: 0 East, 1 West, 2 North, 3 South, 4 Local |

## Verification
The bench targets the quadrants where the policies disagree. The east-and-north case under Negative-first is one of them: a design that reused XY order there would send the header East before North, which is a forbidden turn. Busy masks are aimed so that each adaptive policy has to fall back to its second direction. A design with the fallback missing stalls where it should grant, and one with the fallback applied in a deterministic quadrant grants a forbidden detour. Held requests are released one cycle after a stall to expose a design that latches its stall. Coordinates at 0 and 15 are used to catch a comparison that wraps or is signed. A long random sweep against an independent reference confirms that no granted port ever leads away from the target.

// File: rtl/route_pkg.sv
package route_pkg;

  localparam int NUM_PORTS = 5;

  // Port index order is shared by portBusy and routePort
  localparam int P_EAST  = 0;
  localparam int P_WEST  = 1;
  localparam int P_NORTH = 2;
  localparam int P_SOUTH = 3;
  localparam int P_LOCAL = 4;

  typedef enum logic [1:0] {
    ALG_XY     = 2'b00,
    ALG_WFIRST = 2'b01,
    ALG_NLAST  = 2'b10,
    ALG_NFIRST = 2'b11
  } algo_e;

  // Productive directions seen from this switch toward the target
  typedef struct packed {
    logic goEast;
    logic goWest;
    logic goNorth;
    logic goSouth;
    logic atHome;
  } dirNeed_t;

  // Strobes from the policy control into the datapath registers
  typedef struct packed {
    logic                 take;
    logic                 stall;
    logic [NUM_PORTS-1:0] port;
  } ctrlStrobe_t;

endpackage

// File: rtl/route_datapath.sv
module route_datapath
  import route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [COORD_W-1:0]   curX,
  input  logic [COORD_W-1:0]   curY,
  input  logic [COORD_W-1:0]   dstX,
  input  logic [COORD_W-1:0]   dstY,
  input  ctrlStrobe_t          strobe,
  output dirNeed_t             need,
  output logic                 routeValid,
  output logic                 routeStall,
  output logic [NUM_PORTS-1:0] routePort
);

  // Unsigned coordinate comparison; 0 and the all-ones value are ordinary
  always_comb begin
    need.goEast  = dstX > curX;
    need.goWest  = dstX < curX;
    need.goSouth = dstY > curY;
    need.goNorth = dstY < curY;
    need.atHome  = (dstX == curX) && (dstY == curY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeValid <= 1'b0;
      routeStall <= 1'b0;
    end else begin
      routeValid <= strobe.take;
      routeStall <= strobe.stall;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portReg
    always_ff @(posedge clk) begin
      if (!rstN) routePort[p] <= 1'b0;
      else       routePort[p] <= strobe.take & strobe.port[p];
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |-> ($countones(routePort) == 1));                           // R1

  AST_STALL_NO_PORT: assert property (@(posedge clk) disable iff (!rstN)
    routeStall |-> (!routeValid && routePort == '0));                        // R8

  AST_LOCAL_ONLY_HOME: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |-> (routePort[P_LOCAL] ==
      (($past(dstX) == $past(curX)) && ($past(dstY) == $past(curY)))));      // R2

  AST_MIN_EAST: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routePort[P_EAST]) |-> ($past(dstX) > $past(curX)));      // R3

  AST_MIN_WEST: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routePort[P_WEST]) |-> ($past(dstX) < $past(curX)));      // R3

  AST_MIN_SOUTH: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routePort[P_SOUTH]) |-> ($past(dstY) > $past(curY)));     // R3

  AST_MIN_NORTH: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routePort[P_NORTH]) |-> ($past(dstY) < $past(curY)));     // R3

endmodule

// File: rtl/route_ctrl.sv
module route_ctrl
  import route_pkg::*;
(
  input  logic                 reqValid,
  input  logic [1:0]           algoSel,
  input  dirNeed_t             need,
  input  logic [NUM_PORTS-1:0] portBusy,
  output ctrlStrobe_t          strobe
);

  algo_e                algo;
  logic [NUM_PORTS-1:0] xDir;
  logic [NUM_PORTS-1:0] yDir;
  logic [NUM_PORTS-1:0] firstPick;
  logic [NUM_PORTS-1:0] secondPick;
  logic [NUM_PORTS-1:0] freeMask;
  logic [NUM_PORTS-1:0] firstFree;
  logic [NUM_PORTS-1:0] secondFree;
  logic [NUM_PORTS-1:0] chosen;
  logic                 adaptive;
  logic                 northOnly;

  assign algo = algo_e'(algoSel);

  // Single productive port per axis
  always_comb begin
    xDir = '0;
    yDir = '0;
    if (need.goEast)       xDir[P_EAST]  = 1'b1;
    else if (need.goWest)  xDir[P_WEST]  = 1'b1;
    if (need.goNorth)      yDir[P_NORTH] = 1'b1;
    else if (need.goSouth) yDir[P_SOUTH] = 1'b1;
  end

  // Quadrants in which the selected policy permits a second choice
  always_comb begin
    adaptive  = 1'b0;
    northOnly = 1'b0;
    case (algo)
      ALG_XY:     adaptive = 1'b0;
      ALG_WFIRST: adaptive = need.goEast;
      ALG_NLAST:  adaptive = need.goSouth;
      ALG_NFIRST: begin
        adaptive  = (need.goWest && need.goNorth) || (need.goEast && need.goSouth);
        northOnly = need.goEast && need.goNorth;
      end
      default:    adaptive = 1'b0;
    endcase
  end

  // Preferred and fallback candidates: X axis ahead of Y axis
  always_comb begin
    firstPick  = '0;
    secondPick = '0;
    if (need.atHome) begin
      firstPick[P_LOCAL] = 1'b1;
    end else if (northOnly) begin
      firstPick = yDir;
    end else if (|xDir) begin
      firstPick = xDir;
      if (adaptive) secondPick = yDir;
    end else begin
      firstPick = yDir;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_free
    assign freeMask[p] = ~portBusy[p];
  end

  assign firstFree  = firstPick & freeMask;
  assign secondFree = secondPick & freeMask;
  assign chosen     = (|firstFree) ? firstFree : secondFree;

  always_comb begin
    strobe.port  = chosen;
    strobe.take  = reqValid && (|chosen);
    strobe.stall = reqValid && !(|chosen);
  end

endmodule

// File: rtl/turn_route_unit.sv
module turn_route_unit
  import route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         algoSel,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [4:0]         portBusy,
  output logic               routeValid,
  output logic               routeStall,
  output logic [4:0]         routePort
);

  dirNeed_t    need;
  ctrlStrobe_t strobe;

  route_datapath #(.COORD_W(COORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .curX       (curX),
    .curY       (curY),
    .dstX       (dstX),
    .dstY       (dstY),
    .strobe     (strobe),
    .need       (need),
    .routeValid (routeValid),
    .routeStall (routeStall),
    .routePort  (routePort)
  );

  route_ctrl u_ctrl (
    .reqValid (reqValid),
    .algoSel  (algoSel),
    .need     (need),
    .portBusy (portBusy),
    .strobe   (strobe)
  );

  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |-> (($past(portBusy) & routePort) == 5'b0));                 // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!routeValid && !routeStall));                             // R9

  AST_ANSWER_EACH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (routeValid || routeStall));                                // R1

  AST_XY_X_BEFORE_Y: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && $past(algoSel) == 2'b00 &&
     (routePort[P_NORTH] || routePort[P_SOUTH])) |-> ($past(dstX) == $past(curX))); // R4

  AST_NF_NO_EAST_NORTH: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && $past(algoSel) == 2'b11 && routePort[P_EAST])
      |-> ($past(dstY) >= $past(curY)));                                     // R7

endmodule

// File: tb/sim_turn_route_unit.sv
module sim_turn_route_unit;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic [1:0] algoSel;
  logic [3:0] curX, curY, dstX, dstY;
  logic [4:0] portBusy;
  logic       routeValid, routeStall;
  logic [4:0] routePort;

  int checks = 0;
  int fails  = 0;
  logic [6:0] expQ[$];
  string      tagQ[$];
  logic [6:0] expItem;
  string      expTag;

  always #2 clk = ~clk;  // 250 MHz

  turn_route_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .algoSel(algoSel),
    .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY), .portBusy(portBusy),
    .routeValid(routeValid), .routeStall(routeStall), .routePort(routePort)
  );

  // Reference: bit 0 E, 1 W, 2 N, 3 S, 4 L; X grows east, Y grows south
  function automatic logic [4:0] refPort(input logic [1:0] alg, input int cx, input int cy,
                                         input int tx, input int ty, input logic [4:0] busy);
    logic e, w, n, s;
    logic [4:0] pa, pb, xd, yd;
    e = tx > cx; w = tx < cx; s = ty > cy; n = ty < cy;
    xd = e ? 5'b00001 : (w ? 5'b00010 : 5'b00000);
    yd = n ? 5'b00100 : (s ? 5'b01000 : 5'b00000);
    pa = 5'b0; pb = 5'b0;
    if (!e && !w && !n && !s) pa = 5'b10000;
    else begin
      case (alg)
        2'd0: pa = (xd != 0) ? xd : yd;
        2'd1: if (e) begin pa = 5'b00001; pb = yd; end
              else pa = (xd != 0) ? xd : yd;
        2'd2: if (s) begin
                if (xd != 0) begin pa = xd; pb = 5'b01000; end
                else pa = 5'b01000;
              end else pa = (xd != 0) ? xd : yd;
        default: if (e && n) pa = 5'b00100;
                 else if ((w && n) || (e && s)) begin pa = xd; pb = yd; end
                 else pa = (xd != 0) ? xd : yd;
      endcase
    end
    if ((pa & ~busy) != 0) return pa;
    if ((pb & ~busy) != 0) return pb;
    return 5'b0;
  endfunction

  // Driver: called at a falling edge, applies one cycle of stimulus
  task automatic drive(input string tag, input logic req, input logic [1:0] alg,
                       input int cx, input int cy, input int tx, input int ty,
                       input logic [4:0] busy);
    logic [4:0] p;
    reqValid = req; algoSel = alg;
    curX = cx[3:0]; curY = cy[3:0]; dstX = tx[3:0]; dstY = ty[3:0];
    portBusy = busy;
    p = refPort(alg, cx, cy, tx, ty, busy);
    expQ.push_back({req && (p != 0), req && (p == 0), req ? p : 5'b0});
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compares one registered answer per cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem = expQ.pop_front();
      expTag  = tagQ.pop_front();
      checks++;
      if ({routeValid, routeStall, routePort} !== expItem) begin
        fails++;
        $display("FAIL %s: got valid=%0b stall=%0b port=%b expected valid=%0b stall=%0b port=%b",
                 expTag, routeValid, routeStall, routePort, expItem[6], expItem[5], expItem[4:0]);
      end
    end
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b1; algoSel = 2'd0;
    curX = 4'd5; curY = 4'd5; dstX = 4'd9; dstY = 4'd9; portBusy = 5'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({routeValid, routeStall, routePort} !== 7'b0) begin
      fails++;
      $display("FAIL R10 reset: got %b expected 0000000", {routeValid, routeStall, routePort});
    end
    rstN = 1'b1;

    drive("R9 idle",                 1'b0, 2'd0, 5, 5, 9, 9, 5'b00000);
    drive("R2 local free",           1'b1, 2'd0, 5, 5, 5, 5, 5'b01111);
    drive("R2 local busy stall",     1'b1, 2'd3, 5, 5, 5, 5, 5'b10000);
    drive("R4 xy east first",        1'b1, 2'd0, 5, 5, 9, 2, 5'b00000);
    drive("R4 xy north after X",     1'b1, 2'd0, 5, 5, 5, 2, 5'b00000);
    drive("R4 xy west first",        1'b1, 2'd0, 5, 5, 2, 9, 5'b00000);
    drive("R4 xy east busy stall",   1'b1, 2'd0, 5, 5, 9, 9, 5'b00001);
    drive("R9 pulse ends",           1'b0, 2'd0, 5, 5, 9, 9, 5'b00000);
    drive("R5 wf east",              1'b1, 2'd1, 5, 5, 9, 9, 5'b00000);
    drive("R5 wf south fallback",    1'b1, 2'd1, 5, 5, 9, 9, 5'b00001);
    drive("R5 wf north fallback",    1'b1, 2'd1, 5, 5, 9, 1, 5'b00001);
    drive("R8 wf both busy stall",   1'b1, 2'd1, 5, 5, 9, 9, 5'b01001);
    drive("R5 wf west no detour",    1'b1, 2'd1, 5, 5, 2, 9, 5'b00010);
    drive("R6 nl west",              1'b1, 2'd2, 5, 5, 2, 9, 5'b00000);
    drive("R6 nl south fallback",    1'b1, 2'd2, 5, 5, 2, 9, 5'b00010);
    drive("R6 nl north side xy",     1'b1, 2'd2, 5, 5, 9, 2, 5'b00001);
    drive("R6 nl north only",        1'b1, 2'd2, 5, 5, 5, 2, 5'b00000);
    drive("R6 nl south only",        1'b1, 2'd2, 5, 5, 5, 9, 5'b00000);
    drive("R7 nf west then south",   1'b1, 2'd3, 5, 5, 2, 9, 5'b00000);
    drive("R7 nf west busy stall",   1'b1, 2'd3, 5, 5, 2, 9, 5'b00010);
    drive("R7 nf north before east", 1'b1, 2'd3, 5, 5, 9, 2, 5'b00000);
    drive("R7 nf north busy stall",  1'b1, 2'd3, 5, 5, 9, 2, 5'b00100);
    drive("R7 nf west-north west",   1'b1, 2'd3, 5, 5, 2, 2, 5'b00000);
    drive("R7 nf west-north north",  1'b1, 2'd3, 5, 5, 2, 2, 5'b00010);
    drive("R7 nf east-south south",  1'b1, 2'd3, 5, 5, 9, 9, 5'b00001);
    drive("R3 corner xy 0 to 15",    1'b1, 2'd0, 0, 0, 15, 15, 5'b00000);
    drive("R3 corner nf 15 to 0",    1'b1, 2'd3, 15, 15, 0, 0, 5'b00000);
    drive("R3 corner wf 15 to 0",    1'b1, 2'd1, 15, 15, 0, 0, 5'b00000);
    drive("R8 held stall",           1'b1, 2'd0, 3, 3, 3, 12, 5'b01000);
    drive("R8 held stall again",     1'b1, 2'd0, 3, 3, 3, 12, 5'b01000);
    drive("R8 held released",        1'b1, 2'd0, 3, 3, 3, 12, 5'b00000);
    drive("R1 single pulse",         1'b0, 2'd0, 3, 3, 3, 12, 5'b00000);

    for (int i = 0; i < 400; i++) begin
      drive("R3 random sweep", ($urandom % 4) != 0, 2'($urandom % 4),
            int'($urandom % 16), int'($urandom % 16),
            int'($urandom % 16), int'($urandom % 16), 5'($urandom % 32));
    end

    drive("R9 final idle", 1'b0, 2'd0, 0, 0, 0, 0, 5'b00000);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule